// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block collects single-cycle event pulses from an Ethernet MAC into one sticky status register and drives a single level interrupt toward the system interrupt controller. Each event source has one status bit and one mask bit. A mask bit of 0 lets its event be captured, and a mask bit of 1 blocks it. After reset every mask bit is 0, so every source is enabled.

Software services the interrupt by reading the status register. The read returns the pending sources and clears the whole register in the same access. For test use, a bus write to the status register loads every implemented bit with the written value, ignoring the mask. That write can raise or drop the interrupt without any MAC activity. The register interface is a simple single-cycle memory-mapped port. Reads are combinational and writes take effect at the clock edge.

Top module: `irq_status_ctl`

## Requirements
- R1: After reset the status register, the mask register and `irq_o` are all 0.
- R2: `evt_i[k]` sets status bit k when mask bit k is 0. The named sources are bit 13 (pause-time counter reached zero), bit 12 (valid pause frame received), bit 11 (DMA got a 'not OK' response) and bit 10 (receive frame lost to overrun).
- R3: An event whose mask bit is 1 leaves its status bit unchanged.
- R4: A set status bit stays set, whatever further events arrive, until a status read or a status write changes it.
- R5: A read of the status register (offset 0x24) returns its current value, and every bit is 0 afterwards.
- R6: An event arriving in the same cycle as a status read does not appear in that read's data, and its bit is set after the clear.
- R7: A write to the status register loads bits 13:0 with the written data, whatever the mask holds. A write in the same cycle as an event takes priority over the event.
- R8: Status and mask bits 31:14 always read as 0 and ignore writes.
- R9: `irq_o` is 1 exactly one cycle after the status register holds a nonzero value, and returns to 0 one cycle after the register becomes 0.
- R10: The mask register at offset 0x28 reads back the last value written to its bits 13:0.
- R11: Reads of any other offset return 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 14 | Event pulses; bit k is source k |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_en` is high with `bus_we` low |
| irq_o | output | 1 | Level interrupt, high while any status bit is set (one cycle later) |

## Verification
The hardest case to reach is an event pulse landing in the very cycle that software reads the status register. That case decides whether an event is lost or double-reported. The bench reaches it with a dedicated scenario that raises an event line on the same falling edge that starts the read strobe. It samples the read data before the clock edge and then issues a second read to show that the late event survived the clear. Setting blocked bits through the test write path, while every source is masked, is also reached only by a dedicated sequence.

// File: rtl/irq_status_ctl.sv
module irq_status_ctl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 14,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h24,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] stat_q, stat_d, mask_q, gated_evt;
  logic               irq_q;

  wire stat_hit = bus_en && (bus_addr == STAT_OFS);
  wire mask_hit = bus_en && (bus_addr == MASK_OFS);
  wire stat_rd  = stat_hit && !bus_we;
  wire stat_wr  = stat_hit && bus_we;
  wire mask_wr  = mask_hit && bus_we;

  assign gated_evt = evt_i & ~mask_q;

  always_comb begin
    if (stat_wr)      stat_d = bus_wdata[NUM_SRC-1:0];
    else if (stat_rd) stat_d = gated_evt;
    else              stat_d = stat_q | gated_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (mask_wr) mask_q <= bus_wdata[NUM_SRC-1:0];
      irq_q  <= |stat_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (bus_addr == STAT_OFS)      bus_rdata[NUM_SRC-1:0] = stat_q;
      else if (bus_addr == MASK_OFS) bus_rdata[NUM_SRC-1:0] = mask_q;
    end
  end

  assign irq_o = irq_q;

  logic unused_hi;
  assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

endmodule

module irq_status_ctl_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 14,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h24,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h28
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               bus_en,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q
);

  wire c_srd = bus_en && !bus_we && (bus_addr == STAT_OFS);
  wire c_swr = bus_en && bus_we && (bus_addr == STAT_OFS);
  wire c_mwr = bus_en && bus_we && (bus_addr == MASK_OFS);

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|$past(stat_q)));

  p_masked_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !c_swr |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_swr && !c_srd) |=> ((~stat_q & $past(stat_q)) == '0));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_srd |=> ((stat_q & ~$past(evt_i)) == '0));

  p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_swr |=> (stat_q == $past(bus_wdata[NUM_SRC-1:0])));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |-> (bus_rdata[DATA_W-1:NUM_SRC] == '0));

  p_mask_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    c_mwr |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

endmodule

bind irq_status_ctl irq_status_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
  .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/irq_status_ctl_tb.sv
module irq_status_ctl_tb;
  localparam logic [7:0] STAT = 8'h24;
  localparam logic [7:0] MASK = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] evt_i = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_status_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic pulse(logic [13:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    bus_read(MASK, d); check("R1 mask", d, 32'h0);
    bus_read(STAT, d); check("R1 status", d, 32'h0);
  endtask

  task automatic t_capture_irq();
    logic [31:0] d;
    pulse(14'h2000);
    check("R9 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R9 irq raised", {31'b0, irq_o}, 32'h1);
    bus_read(STAT, d); check("R2 bit13", d, 32'h2000);
    check("R9 irq lag on clear", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R9 irq dropped", {31'b0, irq_o}, 32'h0);
    pulse(14'h3C00);
    bus_read(STAT, d); check("R2 four named sources", d, 32'h3C00);
    bus_read(STAT, d); check("R5 cleared", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_write(MASK, 32'h0000_0400);
    bus_read(MASK, d); check("R10 mask readback", d, 32'h400);
    pulse(14'h0C00);
    bus_read(STAT, d); check("R3 masked bit10 blocked", d, 32'h800);
    bus_write(MASK, 32'hFFFF_FFFF);
    bus_read(MASK, d); check("R8 mask reserved", d, 32'h3FFF);
    pulse(14'h3FFF);
    bus_read(STAT, d); check("R3 all masked", d, 32'h0);
    check("R3 no irq", {31'b0, irq_o}, 32'h0);
    bus_write(MASK, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(14'h1000);
    repeat (3) @(negedge clk);
    pulse(14'h1000);
    pulse(14'h0001);
    bus_read(STAT, d); check("R4 sticky", d, 32'h1001);
    bus_read(STAT, d); check("R5 read clears all", d, 32'h0);
  endtask

  task automatic t_read_collision();
    logic [31:0] d;
    pulse(14'h0400);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = STAT; evt_i = 14'h0800;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0; evt_i = '0;
    check("R6 read returns old", d, 32'h400);
    bus_read(STAT, d); check("R6 late event kept", d, 32'h800);
  endtask

  task automatic t_test_write();
    logic [31:0] d;
    bus_write(MASK, 32'h3FFF);
    bus_write(STAT, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R7 write raises irq", {31'b0, irq_o}, 32'h1);
    bus_write(STAT, 32'h0000_02A0);
    bus_write(STAT, 32'h0);
    @(negedge clk);
    check("R7 write clears irq", {31'b0, irq_o}, 32'h0);
    bus_write(STAT, 32'hFFFF_C155);
    bus_read(STAT, d); check("R7 R8 write load", d, 32'h0155);
    bus_write(MASK, 32'h0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = STAT; bus_wdata = 32'h0002; evt_i = 14'h0004;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; evt_i = '0;
    bus_read(STAT, d); check("R7 write beats event", d, 32'h0002);
  endtask

  task automatic t_other_addr();
    logic [31:0] d;
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h2C, 32'hFFFF_FFFF);
    bus_read(8'h10, d); check("R11 other read", d, 32'h0);
    bus_read(STAT, d); check("R11 status untouched", d, 32'h0);
    bus_read(MASK, d); check("R11 mask untouched", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture_irq();
    t_mask();
    t_sticky();
    t_read_collision();
    t_test_write();
    t_other_addr();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule